// File: doc/BRIEF.md
# Precision-Time Receive Sample Classifier

This block watches the byte stream of each received Ethernet frame and decides, from the frame's leading headers alone, whether the frame's arrival time should be captured for clock synchronisation. It recognises two carriers for timing messages: messages sent directly over Ethernet with their own EtherType, and messages inside IPv4/UDP datagrams addressed to the event or general port. It pulls out the protocol version and message type, then filters them against a set of configurable rules. These rules are an enable bit, a 2-bit mode, a UDP port select, and two match fields for each of the two protocol versions, where some codes act as wildcards.

The decision is a single registered pulse per frame. It is raised one cycle after the byte that settles the outcome. If the frame ends before an outcome is settled, the pulse carries a reject. Configuration is held in a small register with two load strobes. One strobe loads enable, mode and port select. The other loads the four match fields.

The parser is one state machine with six named states. ST_IDLE waits for a start byte. ST_ETH counts the 14 Ethernet header bytes. ST_IP walks an IPv4 header of the length given by its IHL field. ST_UDP walks the 8 UDP header bytes. ST_PTP reads the timing header. ST_DONE holds a decided frame until its end.

The transitions are:
- Start byte: any state goes to ST_ETH.
- EtherType 0x0800 goes to ST_IP.
- EtherType 0x88F7 goes to ST_PTP.
- Last IP header byte goes to ST_UDP.
- Eighth UDP byte goes to ST_PTP.
- Any decision goes to ST_DONE.
- End byte: any state goes to ST_IDLE.

Top module: `ptp_rx_classifier`

## Requirements
- R1: While the enable bit is 0, dec_sample is never 1.
- R2: The EtherType is frame bytes 12 and 13, most significant byte first. With 0x0800, the IPv4 header starts at byte 14. Its length is 4 times the low nibble of byte 14, and an IHL below 5 rejects. A protocol byte (IP byte 9) other than 17 rejects. With 0x88F7, the timing header starts at byte 14. Any other EtherType rejects.
- R3: For UDP frames, mode 0 rejects. The destination port is UDP bytes 2 and 3. Port 319 passes only when port select is 1 or 3. Port 320 passes only when port select is 2 or 3. Any other port rejects.
- R4: A frame carried directly over Ethernet is rejected in mode 1.
- R5: A version-1 header has timing bytes 0 and 1 equal to 0x00 and 0x01, and its message type at timing byte 20. It is accepted only in mode 1, and only when either v1 match field is 0xFF or the type equals one of them.
- R6: A version-2 header is any header that is not version 1 and has timing byte 1 equal to 0x02. Its type is timing byte 0. It is rejected in mode 1. In mode 3 it is accepted when the type is below 8. In modes 0 and 2 it is accepted when v2 match field A is 0xF or the type equals match field A or B (zero-extended).
- R7: After reset, enable = 0, mode = 0, port select = 0, v1 match A = 0, v2 match A = 0, v1 match B = 1 and v2 match B = 1. ctl_load writes enable, mode and port select. match_load writes only the four match fields.
- R8: Each frame that ends with frm_eop gives exactly one dec_valid pulse. The pulse comes one cycle after the byte that settles the outcome, or one cycle after the end byte when the header is too short, in which case it is a reject. dec_sample is 1 only with dec_valid.
- R9: A start byte that arrives while a frame is still open drops that frame without a pulse and begins parsing the new frame at byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_sop | input | 1 | Qualifies the first byte of a frame |
| frm_valid | input | 1 | frm_data carries a byte this cycle |
| frm_data | input | 8 | Frame byte |
| frm_eop | input | 1 | Qualifies the last byte of a frame |
| ctl_load | input | 1 | Load strobe for enable, mode and port select |
| ctl_enable | input | 1 | Global sampling enable |
| ctl_mode | input | 2 | Transport/version mode |
| ctl_port_sel | input | 2 | UDP port select: bit 0 event port 319, bit 1 general port 320 |
| match_load | input | 1 | Load strobe for the four match fields |
| match_v1_a | input | 8 | Version-1 match field A |
| match_v1_b | input | 8 | Version-1 match field B |
| match_v2_a | input | 4 | Version-2 match field A (0xF is a wildcard) |
| match_v2_b | input | 4 | Version-2 match field B |
| dec_valid | output | 1 | One-cycle decision pulse |
| dec_sample | output | 1 | Sample verdict, meaningful with dec_valid |

## Verification
Two things can happen in the same cycle: the byte that settles the verdict can also be the frame's end byte. The bench provokes this with a direct-Ethernet version-2 frame cut to exactly 16 bytes, so the version byte carries frm_eop. It also provokes it with frames truncated at random lengths. In both cases it checks for exactly one pulse carrying the verdict computed by the model, not a second, end-of-frame reject pulse. A start byte that lands on an open frame is judged in the same way: the abandoned frame must add no pulse.

// File: rtl/ptp_cls_pkg.sv
package ptp_cls_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ETH,
        ST_IP,
        ST_UDP,
        ST_PTP,
        ST_DONE
    } parse_st_t;

    typedef struct packed {
        logic       en;
        logic [1:0] mode;
        logic [1:0] port_sel;
        logic [7:0] v1_a;
        logic [7:0] v1_b;
        logic [3:0] v2_a;
        logic [3:0] v2_b;
    } cls_cfg_t;

    localparam logic [15:0] ET_IPV4      = 16'h0800;
    localparam logic [15:0] ET_TIMING    = 16'h88F7;
    localparam logic [7:0]  PROTO_UDP    = 8'd17;
    localparam logic [15:0] PORT_EVENT   = 16'd319;
    localparam logic [15:0] PORT_GENERAL = 16'd320;
    localparam int          ETH_LAST_OFS = 13;
    localparam int          ET_HI_OFS    = 12;
    localparam int          IP_PROTO_OFS = 9;
    localparam int          UDP_PORT_OFS = 2;
    localparam int          UDP_LAST_OFS = 7;
    localparam int          V1_TYPE_OFS  = 20;

    function automatic logic port_pass(input logic [1:0] sel, input logic [15:0] port);
        return (port == PORT_EVENT && sel[0]) || (port == PORT_GENERAL && sel[1]);
    endfunction

    function automatic logic v1_pass(input cls_cfg_t c, input logic [7:0] t);
        if (c.mode != 2'd1) return 1'b0;
        return (c.v1_a == 8'hFF) || (c.v1_b == 8'hFF) || (t == c.v1_a) || (t == c.v1_b);
    endfunction

    function automatic logic v2_pass(input cls_cfg_t c, input logic [7:0] t);
        if (c.mode == 2'd1) return 1'b0;
        if (c.mode == 2'd3) return t < 8'd8;
        return (c.v2_a == 4'hF) || (t == {4'h0, c.v2_a}) || (t == {4'h0, c.v2_b});
    endfunction

endpackage

// File: rtl/ptp_cls_cfg.sv
module ptp_cls_cfg
    import ptp_cls_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_load,
    input  logic       ctl_enable,
    input  logic [1:0] ctl_mode,
    input  logic [1:0] ctl_port_sel,
    input  logic       match_load,
    input  logic [7:0] match_v1_a,
    input  logic [7:0] match_v1_b,
    input  logic [3:0] match_v2_a,
    input  logic [3:0] match_v2_b,
    output cls_cfg_t   cfg
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.en       <= 1'b0;
            cfg.mode     <= 2'd0;
            cfg.port_sel <= 2'd0;
            cfg.v1_a     <= 8'd0;
            cfg.v1_b     <= 8'd1;
            cfg.v2_a     <= 4'd0;
            cfg.v2_b     <= 4'd1;
        end else begin
            if (ctl_load) begin
                cfg.en       <= ctl_enable;
                cfg.mode     <= ctl_mode;
                cfg.port_sel <= ctl_port_sel;
            end
            if (match_load) begin
                cfg.v1_a <= match_v1_a;
                cfg.v1_b <= match_v1_b;
                cfg.v2_a <= match_v2_a;
                cfg.v2_b <= match_v2_b;
            end
        end
    end

    AST_MATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !match_load |=> $stable({cfg.v1_a, cfg.v1_b, cfg.v2_a, cfg.v2_b})); // R7
    AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_load |=> $stable({cfg.en, cfg.mode, cfg.port_sel})); // R7

endmodule

// File: rtl/ptp_rx_classifier.sv
module ptp_rx_classifier
    import ptp_cls_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frm_sop,
    input  logic       frm_valid,
    input  logic [7:0] frm_data,
    input  logic       frm_eop,
    input  logic       ctl_load,
    input  logic       ctl_enable,
    input  logic [1:0] ctl_mode,
    input  logic [1:0] ctl_port_sel,
    input  logic       match_load,
    input  logic [7:0] match_v1_a,
    input  logic [7:0] match_v1_b,
    input  logic [3:0] match_v2_a,
    input  logic [3:0] match_v2_b,
    output logic       dec_valid,
    output logic       dec_sample
);

    localparam logic [IDX_W-1:0] P_ET_HI = IDX_W'(ET_HI_OFS);
    localparam logic [IDX_W-1:0] P_ET_LO = IDX_W'(ETH_LAST_OFS);
    localparam logic [IDX_W-1:0] P_PROTO = IDX_W'(IP_PROTO_OFS);
    localparam logic [IDX_W-1:0] P_PORT  = IDX_W'(UDP_PORT_OFS);
    localparam logic [IDX_W-1:0] P_UEND  = IDX_W'(UDP_LAST_OFS);
    localparam logic [IDX_W-1:0] P_V1T   = IDX_W'(V1_TYPE_OFS);

    cls_cfg_t cfg;

    ptp_cls_cfg u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl_load     (ctl_load),
        .ctl_enable   (ctl_enable),
        .ctl_mode     (ctl_mode),
        .ctl_port_sel (ctl_port_sel),
        .match_load   (match_load),
        .match_v1_a   (match_v1_a),
        .match_v1_b   (match_v1_b),
        .match_v2_a   (match_v2_a),
        .match_v2_b   (match_v2_b),
        .cfg          (cfg)
    );

    parse_st_t        st, st_n, cur;
    logic [IDX_W-1:0] idx, idx_n, pos;
    logic [3:0]       ihl_q, ihl_n;
    logic [7:0]       hold_q, hold_n;
    logic             udp_q, udp_n, v1_q, v1_n;
    logic             fire, verdict;

    // next-state and decision logic
    always_comb begin
        st_n    = st;
        idx_n   = idx;
        ihl_n   = ihl_q;
        hold_n  = hold_q;
        udp_n   = udp_q;
        v1_n    = v1_q;
        fire    = 1'b0;
        verdict = 1'b0;
        cur     = st;
        pos     = idx;
        if (frm_valid) begin
            cur = frm_sop ? ST_ETH : st;
            pos = frm_sop ? '0 : idx;
            if (frm_sop) begin
                udp_n = 1'b0;
                v1_n  = 1'b0;
            end
            st_n  = cur;
            idx_n = pos + 1'b1;
            unique case (cur)
                ST_ETH: begin
                    if (pos == P_ET_HI) begin
                        hold_n = frm_data;
                    end else if (pos == P_ET_LO) begin
                        idx_n = '0;
                        if ({hold_q, frm_data} == ET_IPV4) begin
                            st_n = ST_IP;
                        end else if ({hold_q, frm_data} == ET_TIMING && cfg.mode != 2'd1) begin
                            st_n = ST_PTP;
                        end else begin
                            fire = 1'b1;
                        end
                    end
                end
                ST_IP: begin
                    if (pos == '0) begin
                        ihl_n = frm_data[3:0];
                        if (frm_data[3:0] < 4'd5) fire = 1'b1;
                    end else if (pos == P_PROTO && frm_data != PROTO_UDP) begin
                        fire = 1'b1;
                    end
                    if (pos != '0 && pos == {ihl_q, 2'b00} - 1'b1) begin
                        st_n  = ST_UDP;
                        idx_n = '0;
                    end
                end
                ST_UDP: begin
                    if (pos == P_PORT) begin
                        hold_n = frm_data;
                    end else if (pos == P_PORT + 1'b1) begin
                        if (cfg.mode == 2'd0 || !port_pass(cfg.port_sel, {hold_q, frm_data}))
                            fire = 1'b1;
                    end else if (pos == P_UEND) begin
                        st_n  = ST_PTP;
                        idx_n = '0;
                        udp_n = 1'b1;
                    end
                end
                ST_PTP: begin
                    if (pos == '0) begin
                        hold_n = frm_data;
                    end else if (pos == IDX_W'(1)) begin
                        if (hold_q == 8'h00 && frm_data == 8'h01) begin
                            if (cfg.mode != 2'd1) fire = 1'b1;
                            else v1_n = 1'b1;
                        end else if (frm_data == 8'h02) begin
                            fire    = 1'b1;
                            verdict = v2_pass(cfg, hold_q);
                        end else begin
                            fire = 1'b1;
                        end
                    end else if (pos == P_V1T && v1_q) begin
                        fire    = 1'b1;
                        verdict = v1_pass(cfg, frm_data);
                    end
                end
                ST_IDLE, ST_DONE: begin
                end
                default: begin
                end
            endcase
            verdict = verdict & cfg.en;
            if (fire) st_n = ST_DONE;
            if (frm_eop) begin
                if (!fire && cur != ST_IDLE && cur != ST_DONE) begin
                    fire    = 1'b1;
                    verdict = 1'b0;
                end
                st_n = ST_IDLE;
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            idx    <= '0;
            ihl_q  <= 4'd0;
            hold_q <= 8'd0;
            udp_q  <= 1'b0;
            v1_q   <= 1'b0;
        end else begin
            st     <= st_n;
            idx    <= idx_n;
            ihl_q  <= ihl_n;
            hold_q <= hold_n;
            udp_q  <= udp_n;
            v1_q   <= v1_n;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            dec_sample <= 1'b0;
        end else begin
            dec_valid  <= fire;
            dec_sample <= fire & verdict;
        end
    end

    AST_SAMPLE_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        dec_sample |-> dec_valid); // R8
    AST_NO_SAMPLE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        dec_sample |-> $past(cfg.en)); // R1
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_valid |=> !dec_valid); // R8
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DONE && !frm_sop) |=> !dec_valid); // R8
    AST_UDP_MODE0: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_sample && $past(udp_q) && $past(st) == ST_PTP && !$past(frm_sop))
            |-> $past(cfg.mode) != 2'd0); // R3

endmodule

// File: tb/ptp_rx_classifier_tb.sv
`timescale 1ns/1ps
module ptp_rx_classifier_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frm_sop = 1'b0, frm_valid = 1'b0, frm_eop = 1'b0;
    logic [7:0] frm_data = 8'd0;
    logic       ctl_load = 1'b0, ctl_enable = 1'b0;
    logic [1:0] ctl_mode = 2'd0, ctl_port_sel = 2'd0;
    logic       match_load = 1'b0;
    logic [7:0] match_v1_a = 8'd0, match_v1_b = 8'd0;
    logic [3:0] match_v2_a = 4'd0, match_v2_b = 4'd0;
    logic       dec_valid, dec_sample;

    always #2.5 clk = ~clk;

    ptp_rx_classifier u_dut (
        .clk(clk), .rst_n(rst_n), .frm_sop(frm_sop), .frm_valid(frm_valid),
        .frm_data(frm_data), .frm_eop(frm_eop), .ctl_load(ctl_load),
        .ctl_enable(ctl_enable), .ctl_mode(ctl_mode), .ctl_port_sel(ctl_port_sel),
        .match_load(match_load), .match_v1_a(match_v1_a), .match_v1_b(match_v1_b),
        .match_v2_a(match_v2_a), .match_v2_b(match_v2_b),
        .dec_valid(dec_valid), .dec_sample(dec_sample)
    );

    int checks = 0, failures = 0, pulses = 0;
    bit last = 0, finished = 0;
    logic [7:0] fb [0:127];
    int flen = 0;

    // model copy of configuration, set from R7 defaults
    bit m_en = 0; int m_mode = 0, m_sel = 0;
    int m_v1a = 0, m_v1b = 1, m_v2a = 0, m_v2b = 1;

    always @(negedge clk) if (dec_valid) begin pulses++; last = dec_sample; end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic bit model();
        int p, ihl, u, port, t;
        if (flen < 14) return 0;
        if ({fb[12], fb[13]} == 16'h0800) begin
            if (flen < 15) return 0;
            ihl = int'(fb[14][3:0]);
            if (ihl < 5) return 0;
            if (flen < 24 || fb[23] != 8'd17) return 0;
            u = 14 + ihl * 4;
            if (flen < u + 4 || m_mode == 0) return 0;
            port = int'({fb[u+2], fb[u+3]});
            if (!((port == 319 && (m_sel == 1 || m_sel == 3)) ||
                  (port == 320 && (m_sel == 2 || m_sel == 3)))) return 0;
            p = u + 8;
        end else if ({fb[12], fb[13]} == 16'h88F7) begin
            if (m_mode == 1) return 0;
            p = 14;
        end else return 0;
        if (flen < p + 2) return 0;
        if (fb[p] == 8'h00 && fb[p+1] == 8'h01) begin
            if (m_mode != 1 || flen < p + 21) return 0;
            t = int'(fb[p+20]);
            return m_en && (m_v1a == 255 || m_v1b == 255 || t == m_v1a || t == m_v1b);
        end else if (fb[p+1] == 8'h02) begin
            t = int'(fb[p]);
            if (m_mode == 1) return 0;
            if (m_mode == 3) return m_en && (t < 8);
            return m_en && (m_v2a == 15 || t == m_v2a || t == m_v2b);
        end
        return 0;
    endfunction

    task automatic fill_rand(input int n);
        flen = n;
        for (int i = 0; i < 128; i++) fb[i] = 8'($urandom);
    endtask

    task automatic put_ptp(input int p, input int ver, input int t);
        if (ver == 1) begin fb[p] = 8'h00; fb[p+1] = 8'h01; fb[p+20] = 8'(t); end
        else if (ver == 2) begin fb[p] = 8'(t); fb[p+1] = 8'h02; end
        else begin fb[p+1] = 8'h03; end
    endtask

    task automatic mk_l2(input int ver, input int t);
        fill_rand(36);
        fb[12] = 8'h88; fb[13] = 8'hF7;
        put_ptp(14, ver, t);
    endtask

    task automatic mk_udp(input int ihl, input int proto, input int port, input int ver, input int t);
        int u;
        u = 14 + ihl * 4;
        fill_rand(u + 30);
        fb[12] = 8'h08; fb[13] = 8'h00;
        fb[14] = {4'h4, 4'(ihl)}; fb[23] = 8'(proto);
        fb[u+2] = 8'(port >> 8); fb[u+3] = 8'(port);
        put_ptp(u + 8, ver, t);
    endtask

    task automatic set_ctl(input bit en, input int mode, input int sel);
        ctl_enable = en; ctl_mode = 2'(mode); ctl_port_sel = 2'(sel); ctl_load = 1'b1;
        @(negedge clk); ctl_load = 1'b0;
        m_en = en; m_mode = mode; m_sel = sel;
    endtask

    task automatic set_match(input int a1, input int b1, input int a2, input int b2);
        match_v1_a = 8'(a1); match_v1_b = 8'(b1); match_v2_a = 4'(a2); match_v2_b = 4'(b2);
        match_load = 1'b1;
        @(negedge clk); match_load = 1'b0;
        m_v1a = a1 & 255; m_v1b = b1 & 255; m_v2a = a2 & 15; m_v2b = b2 & 15;
    endtask

    task automatic send(input bit with_eop, input bit gaps);
        for (int i = 0; i < flen; i++) begin
            if (gaps) while ($urandom % 4 == 0) begin
                frm_valid = 1'b0; frm_sop = 1'b0; frm_eop = 1'b0;
                @(negedge clk);
            end
            frm_valid = 1'b1; frm_sop = (i == 0); frm_eop = with_eop && (i == flen - 1);
            frm_data = fb[i];
            @(negedge clk);
        end
        frm_valid = 1'b0; frm_sop = 1'b0; frm_eop = 1'b0;
    endtask

    task automatic run_frame(input string tag, input bit gaps);
        bit exp;
        exp = model();
        pulses = 0;
        send(1'b1, gaps);
        repeat (3) @(negedge clk);
        chk(pulses == 1, tag, pulses, 1);
        chk(last == exp, tag, int'(last), int'(exp));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog act=0 exp=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        chk(dec_valid == 1'b0, "R8 reset", int'(dec_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: only ctl loaded, match fields stay at reset values
        set_ctl(1, 1, 3);
        mk_udp(5, 17, 319, 1, 1); run_frame("R7 v1 type1 default B", 0);
        mk_udp(5, 17, 319, 1, 0); run_frame("R7 v1 type0 default A", 0);
        mk_udp(5, 17, 319, 1, 2); run_frame("R7 v1 type2 reject", 0);
        set_ctl(1, 2, 3);
        mk_l2(2, 1); run_frame("R7 v2 type1 default B", 0);
        mk_l2(2, 3); run_frame("R7 v2 type3 reject", 0);

        // R1
        set_ctl(0, 2, 3);
        mk_l2(2, 1); run_frame("R1 disabled", 0);

        // R5 wildcard and match
        set_ctl(1, 1, 1);
        set_match(8'h10, 8'hFF, 2, 3);
        mk_udp(5, 17, 319, 1, 8'h55); run_frame("R5 v1 wildcard", 0);
        set_match(8'h10, 8'h20, 2, 3);
        mk_udp(5, 17, 319, 1, 8'h20); run_frame("R5 v1 match B", 0);
        mk_udp(5, 17, 319, 1, 8'h55); run_frame("R5 v1 miss", 0);
        set_ctl(1, 2, 1);
        mk_udp(5, 17, 319, 1, 8'h10); run_frame("R5 v1 outside mode1", 0);

        // R6
        set_ctl(1, 3, 3);
        mk_l2(2, 7); run_frame("R6 mode3 type7", 0);
        mk_l2(2, 8); run_frame("R6 mode3 type8", 0);
        set_ctl(1, 2, 3);
        set_match(0, 0, 15, 3);
        mk_l2(2, 9); run_frame("R6 v2 wildcard", 0);
        set_match(0, 0, 4, 3);
        mk_udp(5, 17, 320, 2, 3); run_frame("R6 v2 match B", 0);
        mk_udp(5, 17, 320, 2, 5); run_frame("R6 v2 miss", 0);
        set_ctl(1, 1, 3);
        mk_udp(5, 17, 320, 2, 4); run_frame("R6 v2 mode1", 0);

        // R3
        set_ctl(1, 2, 2);
        mk_udp(5, 17, 319, 2, 4); run_frame("R3 port319 sel2", 0);
        mk_udp(5, 17, 320, 2, 4); run_frame("R3 port320 sel2", 0);
        set_ctl(1, 2, 3);
        mk_udp(5, 17, 321, 2, 4); run_frame("R3 port321", 0);
        set_ctl(1, 0, 3);
        mk_udp(5, 17, 319, 2, 4); run_frame("R3 mode0 udp", 0);
        mk_l2(2, 4); run_frame("R3 mode0 l2 passes", 0);

        // R4
        set_ctl(1, 1, 3);
        set_match(255, 1, 15, 1);
        mk_l2(1, 1); run_frame("R4 l2 mode1", 0);

        // R2
        set_ctl(1, 2, 3);
        set_match(0, 0, 4, 3);
        mk_l2(2, 4); fb[12] = 8'h86; fb[13] = 8'hDD; run_frame("R2 other ethertype", 0);
        mk_udp(5, 6, 319, 2, 4); run_frame("R2 proto tcp", 0);
        mk_udp(7, 17, 319, 2, 4); run_frame("R2 ihl7", 0);
        mk_udp(4, 17, 319, 2, 4); run_frame("R2 ihl4", 0);

        // R8: short frame and verdict on end byte
        mk_l2(2, 4); flen = 10; run_frame("R8 short", 0);
        mk_l2(2, 4); flen = 16; run_frame("R8 verdict on eop", 0);
        mk_l2(2, 4); flen = 15; run_frame("R8 cut before version", 0);

        // R9: open frame abandoned by a new start
        pulses = 0;
        mk_udp(5, 17, 319, 2, 4); flen = 20; send(1'b0, 1'b0);
        mk_l2(2, 4);
        begin
            bit e9;
            e9 = model();
            send(1'b1, 1'b0);
            repeat (3) @(negedge clk);
            chk(pulses == 1, "R9 restart pulses", pulses, 1);
            chk(last == e9, "R9 restart verdict", int'(last), int'(e9));
        end

        // random mix
        for (int n = 0; n < 300; n++) begin
            int k, ver, t, port;
            set_ctl(($urandom % 8) != 0, int'($urandom % 4), int'($urandom % 4));
            set_match(($urandom % 4 == 0) ? 255 : int'($urandom % 4),
                      ($urandom % 4 == 0) ? 255 : int'($urandom % 4),
                      int'($urandom % 16), int'($urandom % 16));
            ver = int'($urandom % 3) + 1;
            t = int'($urandom % 12);
            k = int'($urandom % 5);
            port = ($urandom % 2 == 0) ? 319 : (($urandom % 3 == 0) ? 500 : 320);
            if (k == 0) mk_l2(ver, t);
            else if (k == 4) begin mk_l2(ver, t); fb[13] = 8'h00; fb[12] = 8'h08; fb[23] = 8'd6; end
            else mk_udp(5 + int'($urandom % 3), 17, port, ver, t);
            if ($urandom % 8 == 0) flen = 1 + int'($urandom % flen);
            run_frame("R2/R3/R5/R6/R8 random", 1'b1);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule